// File: doc/BRIEF.md
# Protocol and parameters selection exchange parser

This block sits behind the card-side serial receiver and transmitter of a smart-card interface. It handles the short negotiation a reader may open right after the answer to reset. The reader sends a request one byte per receive strobe. The request starts with a fixed initial byte and a format byte. Up to three optional parameter bytes follow, and a check byte closes it. Bits of the format byte say which optional bytes are present. Absent ones are skipped, so the parser always expects the right next byte.

When the check byte arrives, the block tests it against the running XOR of the request. If it is good, the stored request becomes the response. The response is then offered to the transmitter byte by byte with a valid/ready handshake, walking the same step sequence a second time. One phase bit tells the request phase from the response phase. After the final response byte leaves, the block pulses a done flag and presents the newly selected clock-rate and baud-divisor indices with a one-cycle update pulse. If the check fails, the block raises an error pulse, sends nothing and waits for a fresh request.

Top module: `pps_exchange`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tx_valid`, `done`, `chk_err` and `fidi_upd` are 0, and `fi`/`di` hold the parameters `FI_DEF`/`DI_DEF` (default 1 and 1).
- R2: While no response is pending, each cycle with `rx_valid` high accepts `rx_byte`. The order of accepted bytes is: initial byte, format byte, the optional bytes that are present, then the check byte.
- R3: In the format byte, bit 4 announces optional byte 1, bit 5 optional byte 2 and bit 6 optional byte 3. An unannounced byte is skipped, and the next accepted byte is taken as the next announced one or as the check byte.
- R4: A request is valid when the XOR of all its bytes, including the check byte, is zero. On a mismatch, `chk_err` is high for exactly the cycle after the check byte is accepted. `tx_valid` stays 0, and the next accepted byte starts a new request.
- R5: After a valid check byte is accepted, `tx_valid` is 1 in the next cycle, with `tx_byte` equal to the request's initial byte.
- R6: The response repeats the request bytes in request order, including only the bytes that were present. `tx_byte` advances in the cycle after one in which `tx_valid` and `tx_ready` are both high. It holds steady while `tx_ready` is low.
- R7: In the cycle after the response check byte is taken, `tx_valid` falls and `done` and `fidi_upd` are each high for exactly one cycle. If optional byte 1 was present, `fi` takes its bits 7:4 and `di` its bits 3:0.
- R8: If optional byte 1 was absent, `fi`/`di` return to `FI_DEF`/`DI_DEF` at that same update pulse.
- R9: `rx_valid` is ignored while a response is pending; neither the response bytes nor the following request are affected.
- R10: `fi` and `di` change only in a cycle where `fidi_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | BYTE_W | Received byte |
| tx_ready | input | 1 | Transmitter takes `tx_byte` this cycle |
| tx_valid | output | 1 | A response byte is offered |
| tx_byte | output | BYTE_W | Response byte offered |
| done | output | 1 | One-cycle pulse at the end of the response |
| chk_err | output | 1 | One-cycle pulse on a bad check byte |
| fidi_upd | output | 1 | One-cycle pulse when `fi`/`di` take new values |
| fi | output | BYTE_W/2 | Selected clock-rate index |
| di | output | BYTE_W/2 | Selected baud-divisor index |

## Verification
The bench sends requests with every single optional byte alone, with none, and with all three. A design that takes the wrong format bit, or one that fails to skip, would accept the check byte at the wrong step, flag a false error and send a response of the wrong length. Corrupted check bytes, followed by a good request, catch a parser that sends anyway or keeps a stale XOR. A stalling transmitter and strobes of junk during the response catch a byte that moves without a handshake, or receive logic that overwrites the stored frame. An exchange without optional byte 1 after one with it catches indices that keep their old values instead of returning to the defaults.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Step index of the sequencer; order is behaviour (bytes arrive in it).
  typedef enum logic [3:0] {
    STP_START = 4'd0,
    STP_FMT   = 4'd1,
    STP_OPT1  = 4'd2,
    STP_OPT2  = 4'd3,
    STP_OPT3  = 4'd4,
    STP_CHK   = 4'd5
  } step_e;

  // Bit 4 marks the response phase, low nibble is the step.
  typedef struct packed {
    logic  resp;
    step_e step;
  } seq_t;

  localparam int FRAME_LEN = 6;
  localparam int HAS_LSB   = 4;   // first presence bit inside the format byte
  localparam int HAS_W     = 3;   // number of optional bytes
endpackage

// File: rtl/pps_step_next.sv
module pps_step_next
  import pps_pkg::*;
(
  input  step_e            cur,
  input  logic [HAS_W-1:0] has,
  output step_e            nxt
);
  always_comb begin
    unique case (cur)
      STP_START: nxt = STP_FMT;
      STP_FMT:   nxt = has[0] ? STP_OPT1 : has[1] ? STP_OPT2 : has[2] ? STP_OPT3 : STP_CHK;
      STP_OPT1:  nxt = has[1] ? STP_OPT2 : has[2] ? STP_OPT3 : STP_CHK;
      STP_OPT2:  nxt = has[2] ? STP_OPT3 : STP_CHK;
      STP_OPT3:  nxt = STP_CHK;
      default:   nxt = STP_START;
    endcase
  end
endmodule

// File: rtl/pps_xor_chk.sv
module pps_xor_chk #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic [BYTE_W-1:0] din,
  output logic              sum_ok
);
  logic [BYTE_W-1:0] acc;

  assign sum_ok = ((acc ^ din) == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc ^ din;
  end
endmodule

// File: rtl/pps_frame_regs.sv
module pps_frame_regs
  import pps_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = FRAME_LEN,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              copy_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] req_first,
  output logic [HAS_W-1:0]  req_has,
  output logic [HAS_W-1:0]  resp_has,
  output logic [BYTE_W-1:0] resp_opt1
);
  localparam int FMT_POS  = int'(STP_FMT);
  localparam int OPT1_POS = int'(STP_OPT1);

  logic [BYTE_W-1:0] req_q  [DEPTH];
  logic [BYTE_W-1:0] resp_q [DEPTH];

  // Request store with write port; response store loaded as a whole,
  // taking the byte being written this cycle (the check byte) directly.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && wr_idx == IDX_W'(i)) req_q[i] <= wr_data;
      if (copy_en)
        resp_q[i] <= (wr_en && wr_idx == IDX_W'(i)) ? wr_data : req_q[i];
    end
  end

  assign rd_data   = resp_q[rd_idx];
  assign req_first = req_q[0];
  assign req_has   = req_q[FMT_POS][HAS_LSB +: HAS_W];
  assign resp_has  = resp_q[FMT_POS][HAS_LSB +: HAS_W];
  assign resp_opt1 = resp_q[OPT1_POS];
endmodule

// File: rtl/pps_exchange.sv
module pps_exchange
  import pps_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FI_DEF = 1,
  parameter int DI_DEF = 1,
  localparam int NIB_W = BYTE_W / 2,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              done,
  output logic              chk_err,
  output logic              fidi_upd,
  output logic [NIB_W-1:0]  fi,
  output logic [NIB_W-1:0]  di
);
  seq_t              seq;
  step_e             nxt_step;
  logic [HAS_W-1:0]  has_sel, req_has, resp_has;
  logic [BYTE_W-1:0] rd_data, req_first, resp_opt1;
  logic              rx_take, tx_take, last_rx, sum_ok;

  assign rx_take = rx_valid && !seq.resp;
  assign tx_take = tx_valid && tx_ready;
  assign last_rx = rx_take && (seq.step == STP_CHK);

  // The format byte decides skipping while it is itself being received.
  always_comb begin
    if (seq.resp)                 has_sel = resp_has;
    else if (seq.step == STP_FMT) has_sel = rx_byte[HAS_LSB +: HAS_W];
    else                          has_sel = req_has;
  end

  pps_step_next u_next (
    .cur (seq.step),
    .has (has_sel),
    .nxt (nxt_step)
  );

  pps_xor_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (rx_take),
    .clr    (last_rx),
    .din    (rx_byte),
    .sum_ok (sum_ok)
  );

  pps_frame_regs #(.BYTE_W(BYTE_W), .DEPTH(FRAME_LEN)) u_regs (
    .clk       (clk),
    .wr_en     (rx_take),
    .wr_idx    (IDX_W'(seq.step)),
    .wr_data   (rx_byte),
    .copy_en   (last_rx && sum_ok),
    .rd_idx    (IDX_W'(nxt_step)),
    .rd_data   (rd_data),
    .req_first (req_first),
    .req_has   (req_has),
    .resp_has  (resp_has),
    .resp_opt1 (resp_opt1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq      <= '{resp: 1'b0, step: STP_START};
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      done     <= 1'b0;
      chk_err  <= 1'b0;
      fidi_upd <= 1'b0;
      fi       <= NIB_W'(FI_DEF);
      di       <= NIB_W'(DI_DEF);
    end else begin
      done     <= 1'b0;
      chk_err  <= 1'b0;
      fidi_upd <= 1'b0;
      if (rx_take) begin
        seq.step <= nxt_step;
        if (seq.step == STP_CHK) begin
          if (sum_ok) begin
            seq.resp <= 1'b1;
            tx_valid <= 1'b1;
            tx_byte  <= req_first;
          end else begin
            chk_err  <= 1'b1;
          end
        end
      end else if (tx_take) begin
        seq.step <= nxt_step;
        if (seq.step == STP_CHK) begin
          seq.resp <= 1'b0;
          tx_valid <= 1'b0;
          done     <= 1'b1;
          fidi_upd <= 1'b1;
          if (resp_has[0]) begin
            fi <= resp_opt1[BYTE_W-1 -: NIB_W];
            di <= resp_opt1[NIB_W-1:0];
          end else begin
            fi <= NIB_W'(FI_DEF);
            di <= NIB_W'(DI_DEF);
          end
        end else begin
          tx_byte <= rd_data;
        end
      end
    end
  end

  // R1: outputs idle in the first cycle after reset release
  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!tx_valid && !done && !chk_err && !fidi_upd &&
                    fi == NIB_W'(FI_DEF) && di == NIB_W'(DI_DEF)));

  // R3: the step index never leaves the six legal steps
  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    seq.step <= STP_CHK);

  // R4: a bad check byte never opens a response
  assert_err_no_resp_R4: assert property (@(posedge clk) disable iff (rst)
    chk_err |-> !tx_valid);

  // R5: the offer flag and the phase bit agree
  assert_phase_match_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid == seq.resp);

  // R6: an untaken byte holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R7: done is a single-cycle pulse, paired with the update pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_upd_done_R7: assert property (@(posedge clk) disable iff (rst)
    fidi_upd == done);
  assert_end_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> done);

  // R10: indices move only with the update pulse
  assert_fidi_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !fidi_upd |-> ($stable(fi) && $stable(di)));
endmodule

// File: tb/pps_exchange_tb_top.sv
module pps_exchange_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_ready = 1'b0;
  logic       tx_valid, done, chk_err, fidi_upd;
  logic [7:0] tx_byte;
  logic [3:0] fi, di;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pps_exchange dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .done(done), .chk_err(chk_err), .fidi_upd(fidi_upd), .fi(fi), .di(di)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] req_q[$];
  logic [7:0] resp_q[$];
  int  need = 99;
  bit  m_resp = 0, m_done = 0, m_err = 0;
  logic [3:0] m_fi = 4'd1, m_di = 4'd1;
  logic [7:0] m_fmt, m_opt1;

  always @(posedge clk) begin
    if (rst) begin
      req_q.delete(); resp_q.delete(); need = 99;
      m_resp = 0; m_done = 0; m_err = 0; m_fi = 4'd1; m_di = 4'd1;
    end else begin
      m_done = 0; m_err = 0;
      if (m_resp) begin
        if (tx_ready) begin
          void'(resp_q.pop_front());
          if (resp_q.size() == 0) begin
            m_resp = 0; m_done = 1;
            if (m_fmt[4]) begin m_fi = m_opt1[7:4]; m_di = m_opt1[3:0]; end
            else begin m_fi = 4'd1; m_di = 4'd1; end
          end
        end
      end else if (rx_valid) begin
        logic [7:0] x;
        req_q.push_back(rx_byte);
        if (req_q.size() == 2)
          need = 3 + int'(rx_byte[4]) + int'(rx_byte[5]) + int'(rx_byte[6]);
        if (req_q.size() == need) begin
          x = '0;
          foreach (req_q[i]) x ^= req_q[i];
          if (x == 0) begin
            resp_q = req_q; m_resp = 1;
            m_fmt = req_q[1]; m_opt1 = req_q[2];
          end else m_err = 1;
          req_q.delete(); need = 99;
        end
      end
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      cmp("R5 tx_valid", int'(tx_valid), int'(m_resp));
      if (m_resp) cmp("R6 tx_byte", int'(tx_byte), int'(resp_q[0]));
      cmp("R7 done", int'(done), int'(m_done));
      cmp("R7 fidi_upd", int'(fidi_upd), int'(m_done));
      cmp("R4 chk_err", int'(chk_err), int'(m_err));
      cmp("R10 fi", int'(fi), int'(m_fi));
      cmp("R10 di", int'(di), int'(m_di));
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] got_q[$];

  function automatic logic [7:0] pck_of(input logic [7:0] b[$]);
    logic [7:0] x = '0;
    foreach (b[i]) x ^= b[i];
    return x;
  endfunction

  task automatic send_req(input logic [7:0] b[$]);
    foreach (b[i]) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = b[i];
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic drain(input int stall_mod, input bit junk);
    int n = 0;
    got_q.delete();
    forever begin
      @(negedge clk);
      if (!tx_valid) begin
        tx_ready = 1'b0; rx_valid = 1'b0;
        break;
      end
      rx_valid = junk; rx_byte = 8'hFF;
      tx_ready = (stall_mod == 0) ? 1'b1 : ((n % stall_mod) != stall_mod - 1);
      if (tx_ready) got_q.push_back(tx_byte);
      n++;
    end
  endtask

  task automatic exchange(input logic [7:0] body[$], input int stall_mod,
                          input bit junk, input string tag);
    logic [7:0] full[$];
    full = body;
    full.push_back(pck_of(body));
    send_req(full);
    drain(stall_mod, junk);
    cmp({tag, " response length"}, got_q.size(), full.size());
    foreach (full[i])
      if (i < got_q.size()) cmp({tag, " response byte"}, int'(got_q[i]), int'(full[i]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    cmp("R1 tx_valid", int'(tx_valid), 0);
    cmp("R1 fi", int'(fi), 1);
    cmp("R1 di", int'(di), 1);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 done", int'(done), 0);

    exchange('{8'hFF, 8'h00}, 0, 0, "R2");
    cmp("R8 fi default", int'(fi), 1);
    exchange('{8'hFF, 8'h10, 8'h94}, 3, 0, "R3 opt1");
    cmp("R7 fi", int'(fi), 9);
    cmp("R7 di", int'(di), 4);
    exchange('{8'hFF, 8'h20, 8'h05}, 2, 0, "R3 opt2");
    cmp("R8 fi back to default", int'(fi), 1);
    cmp("R8 di back to default", int'(di), 1);
    exchange('{8'hFF, 8'h40, 8'h3C}, 0, 0, "R3 opt3");
    exchange('{8'hFF, 8'h71, 8'h13, 8'h01, 8'h02}, 4, 0, "R3 all");
    cmp("R7 di all", int'(di), 3);

    // R4: bad check byte, then a good request must still work
    send_req('{8'hFF, 8'h10, 8'h18, 8'h00});
    repeat (3) @(negedge clk);
    cmp("R4 no response", int'(tx_valid), 0);
    exchange('{8'hFF, 8'h10, 8'h18}, 0, 0, "R4 recovery");
    cmp("R7 fi after recovery", int'(fi), 1);
    cmp("R7 di after recovery", int'(di), 8);

    // R9: junk strobes while responding
    exchange('{8'hFF, 8'h50, 8'h25, 8'h07}, 2, 1, "R9");
    exchange('{8'hFF, 8'h30, 8'h96, 8'h00}, 0, 0, "R9 next request");
    cmp("R9 fi", int'(fi), 9);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog (R6): actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule